// File: doc/BRIEF.md
# Dual-Channel Input Capture

This block timestamps signal transitions on two independent input pins. Each channel takes its pin asynchronously, passes it through a synchronizer and watches for a transition of the programmed polarity. When one arrives, the channel copies a shared 16-bit free-running timer into its own capture register. It then raises its own interrupt request.

Software sets up the channels and reads results over a small byte-wide register bus. A control byte claims each pin for capture and picks the edge polarity for each channel. A status byte holds sticky interrupt flags and overrun flags, and software clears them by writing ones. Each capture value is read as two bytes. Reading the low byte freezes the high byte, so the two halves of one read always come from the same capture.

Top module: `icap_dual`

## Requirements
- R1: After reset, the control byte, the status byte and both capture registers read zero, and `irq_o` and `pin_claim_o` are low.
- R2: Address 0 is the control byte. Bit c (c = 0, 1) activates channel c and bit 2+c selects its polarity (1 = rising, 0 = falling). The byte reads back as written, and `pin_claim_o[c]` equals bit c from the clock edge after the write onward.
- R3: A pin change that reaches the first synchronizer flop at rising edge k causes a capture at edge k+2. The captured value is `timer_i` as sampled at edge k+2, and `irq_o[c]` goes high after edge k+2 and not earlier.
- R4: A transition of the polarity opposite to the selected one causes no capture and sets no flag.
- R5: While the activate bit of a channel is 0, its pin transitions leave its capture register and flag unchanged.
- R6: Writing new activate or polarity bits while the pin is steady causes no capture.
- R7: Each capture sets status bit c and `irq_o[c]`. The flag stays set until software writes 1 to status bit c at address 1. Writing 0 to it has no effect.
- R8: A capture while flag c is already set still overwrites the capture register and also sets the overrun bit at status bit 2+c. The overrun bit clears only when software writes 1 to it.
- R9: Channel c's capture value is read at address 2+2c (low byte) and address 3+2c (high byte). Reading the low byte snapshots the whole value, and the high byte then returns the snapshot even if a newer capture has arrived.
- R10: A capture on one channel leaves the other channel's register, flag and overrun bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 2 | Asynchronous capture pins, one per channel |
| timer_i | input | 16 | Free-running timer value |
| bus_addr_i | input | 3 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe (arms the high-byte snapshot) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| pin_claim_o | output | 2 | Pin claimed for capture, per channel |
| irq_o | output | 2 | Per-channel interrupt request (sticky flag) |

## Verification
The hardest case to produce is a capture that lands between the two byte reads of one capture register. The capture must also move the high byte, which needs two captures more than 256 timer ticks apart. The directed part reads the low byte, waits about 300 cycles, fires a second capture and only then reads the high byte. Overrun is reached in the same deliberate way: two qualifying edges without a clear in between. The random phase then mixes control rewrites, pin toggles and partial clears so that these cases also occur in varied orders.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_CAP  = 2;

  function automatic int cap_addr(input int ch, input int byte_idx, input int nbytes);
    return ADDR_CAP + ch * nbytes + byte_idx;
  endfunction
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pin_s_i,
  input  logic          act_i,
  input  logic          rise_sel_i,
  input  logic [TW-1:0] timer_i,
  input  logic          flag_clr_i,
  input  logic          ovr_clr_i,
  output logic [TW-1:0] cap_o,
  output logic          flag_o,
  output logic          ovr_o
);
  logic          prev_q;
  logic          rise, fall, hit;
  logic [TW-1:0] cap_q;
  logic          flag_q, ovr_q;

  // edge detection is independent of the polarity bit, so changing it cannot fake an edge
  assign rise = pin_s_i & ~prev_q;
  assign fall = ~pin_s_i & prev_q;
  assign hit  = act_i & (rise_sel_i ? rise : fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cap_q  <= '0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      prev_q <= pin_s_i;
      if (hit) cap_q <= timer_i;
      // set wins over a clear in the same cycle
      if (hit)             flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      if (hit && flag_q)   ovr_q  <= 1'b1;
      else if (ovr_clr_i)  ovr_q  <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/icap_regfile.sv
module icap_regfile
  import icap_pkg::*;
#(
  parameter int N_CH = 2,
  parameter int TW   = 16,
  parameter int AW   = 3,
  parameter int DW   = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [AW-1:0]             addr_i,
  input  logic                      we_i,
  input  logic                      re_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [DW-1:0]             rdata_o,
  input  logic [N_CH-1:0][TW-1:0]   cap_i,
  input  logic [N_CH-1:0]           flag_i,
  input  logic [N_CH-1:0]           ovr_i,
  output logic [N_CH-1:0]           act_o,
  output logic [N_CH-1:0]           rise_sel_o,
  output logic [N_CH-1:0]           flag_clr_o,
  output logic [N_CH-1:0]           ovr_clr_o
);
  localparam int NB = TW / DW;
  localparam int CW = 2 * N_CH;

  logic [CW-1:0]                 ctrl_q;
  logic [N_CH-1:0][TW-DW-1:0]    snap_q;
  logic                          ctrl_wr, stat_wr;

  assign ctrl_wr = we_i && (addr_i == AW'(ADDR_CTRL));
  assign stat_wr = we_i && (addr_i == AW'(ADDR_STAT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata_i[CW-1:0];
  end

  assign act_o      = ctrl_q[N_CH-1:0];
  assign rise_sel_o = ctrl_q[CW-1:N_CH];
  assign flag_clr_o = stat_wr ? wdata_i[N_CH-1:0]  : '0;
  assign ovr_clr_o  = stat_wr ? wdata_i[CW-1:N_CH] : '0;

  generate
    if (DW > CW) begin : g_unused
      logic unused_wdata;
      assign unused_wdata = ^wdata_i[DW-1:CW];
    end
  endgenerate

  // reading the low byte freezes the upper bytes
  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_snap
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          snap_q[c] <= '0;
        else if (re_i && addr_i == AW'(cap_addr(c, 0, NB)))
          snap_q[c] <= cap_i[c][TW-1:DW];
      end
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADDR_CTRL)) rdata_o[CW-1:0] = ctrl_q;
    if (addr_i == AW'(ADDR_STAT)) rdata_o[CW-1:0] = {ovr_i, flag_i};
    for (int c = 0; c < N_CH; c++) begin
      if (addr_i == AW'(cap_addr(c, 0, NB))) rdata_o = cap_i[c][DW-1:0];
      for (int b = 1; b < NB; b++) begin
        if (addr_i == AW'(cap_addr(c, b, NB))) rdata_o = snap_q[c][(b-1)*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/icap_dual.sv
module icap_dual #(
  parameter int N_CH        = 2,
  parameter int TW          = 16,
  parameter int AW          = 3,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] pin_i,
  input  logic [TW-1:0]   timer_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic            bus_we_i,
  input  logic            bus_re_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic [N_CH-1:0] pin_claim_o,
  output logic [N_CH-1:0] irq_o
);
  logic [N_CH-1:0]          sync_w, act_w, rise_w, flag_clr_w, ovr_clr_w;
  logic [N_CH-1:0]          flag_w, ovr_w;
  logic [N_CH-1:0][TW-1:0]  cap_w;

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (pin_i[c]),
        .q_o   (sync_w[c])
      );
      icap_channel #(.TW(TW)) u_ch (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pin_s_i   (sync_w[c]),
        .act_i     (act_w[c]),
        .rise_sel_i(rise_w[c]),
        .timer_i   (timer_i),
        .flag_clr_i(flag_clr_w[c]),
        .ovr_clr_i (ovr_clr_w[c]),
        .cap_o     (cap_w[c]),
        .flag_o    (flag_w[c]),
        .ovr_o     (ovr_w[c])
      );
    end
  endgenerate

  icap_regfile #(.N_CH(N_CH), .TW(TW), .AW(AW), .DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (bus_addr_i),
    .we_i      (bus_we_i),
    .re_i      (bus_re_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .cap_i     (cap_w),
    .flag_i    (flag_w),
    .ovr_i     (ovr_w),
    .act_o     (act_w),
    .rise_sel_o(rise_w),
    .flag_clr_o(flag_clr_w),
    .ovr_clr_o (ovr_clr_w)
  );

  assign pin_claim_o = act_w;
  assign irq_o       = flag_w;
endmodule

// File: rtl/icap_dual_chk.sv
module icap_dual_chk
  import icap_pkg::*;
#(
  parameter int N_CH = 2,
  parameter int TW   = 16,
  parameter int AW   = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [AW-1:0]            bus_addr_i,
  input logic                     bus_we_i,
  input logic [2*N_CH-1:0]        wdata_i,
  input logic [N_CH-1:0]          pin_claim_i,
  input logic [N_CH-1:0]          irq_i,
  input logic [N_CH-1:0]          ovr_i,
  input logic [N_CH-1:0][TW-1:0]  cap_i
);
  AST_CLAIM_FOLLOWS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == AW'(ADDR_CTRL)) |=> (pin_claim_i == $past(wdata_i[N_CH-1:0]))); // R2

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_c
      AST_IDLE_NO_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pin_claim_i[c] |=> $stable(cap_i[c])); // R5
      AST_IRQ_NEEDS_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_i[c]) |-> $past(pin_claim_i[c])); // R5
      AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_i[c] && !(bus_we_i && bus_addr_i == AW'(ADDR_STAT) && wdata_i[c])) |=> irq_i[c]); // R7
      AST_CAP_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_i[c] != $past(cap_i[c])) |-> irq_i[c]); // R7
      AST_OVR_NEEDS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovr_i[c]) |-> $past(irq_i[c])); // R8
    end
  endgenerate
endmodule

bind icap_dual icap_dual_chk #(.N_CH(N_CH), .TW(TW), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_addr_i (bus_addr_i),
  .bus_we_i   (bus_we_i),
  .wdata_i    (bus_wdata_i[2*N_CH-1:0]),
  .pin_claim_i(pin_claim_o),
  .irq_i      (irq_o),
  .ovr_i      (ovr_w),
  .cap_i      (cap_w)
);

// File: tb/tb_icap_dual.sv
module tb_icap_dual;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pin = 2'b00;
  logic [15:0] tmr = 16'hfff0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  claim, irq;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic [15:0] cap_m [2];
  logic [1:0]  flag_m = '0, ovr_m = '0;
  logic [3:0]  ctrl_m = '0;

  always #4 clk = ~clk;
  always @(posedge clk) tmr <= tmr + 16'd1;

  icap_dual dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .timer_i(tmr),
    .bus_addr_i(addr), .bus_we_i(we), .bus_re_i(re), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .pin_claim_o(claim), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
    if (a == 3'd0) ctrl_m = d[3:0];
    if (a == 3'd1) begin flag_m &= ~d[1:0]; ovr_m &= ~d[3:2]; end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  // capture lands three edges after the drive, with the timer value two ticks later
  task automatic step(input int c, input logic lvl);
    logic [15:0] v;
    logic hit;
    @(negedge clk);
    v = tmr;
    hit = ctrl_m[c] && (pin[c] != lvl) && (ctrl_m[2+c] ? lvl : !lvl);
    pin[c] = lvl;
    repeat (4) @(posedge clk);
    if (hit) begin
      if (flag_m[c]) ovr_m[c] = 1'b1;
      flag_m[c] = 1'b1;
      cap_m[c] = v + 16'd2;
    end
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d, lo, hi;
    rd(3'd1, d);
    chk({tag, " status"}, {24'd0, d}, {28'd0, ovr_m, flag_m});
    chk({tag, " irq"}, {30'd0, irq}, {30'd0, flag_m});
    for (int c = 0; c < 2; c++) begin
      rd(3'(2 + 2*c), lo);
      rd(3'(3 + 2*c), hi);
      chk({tag, " capture"}, {16'd0, hi, lo}, {16'd0, cap_m[c]});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0]  d, lo, hi;
    logic [15:0] v, first;
    int unsigned seed;
    cap_m[0] = '0; cap_m[1] = '0;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 claim", {30'd0, claim}, 32'd0);
    chk("R1 irq", {30'd0, irq}, 32'd0);
    rd(3'd0, d); chk("R1 ctrl", {24'd0, d}, 32'd0);
    check_all("R1 reset");

    // R2 control readback and claim
    wr(3'd0, 8'h09);
    rd(3'd0, d); chk("R2 ctrl readback", {24'd0, d}, 32'h9);
    chk("R2 claim", {30'd0, claim}, 32'h1);

    // R5 inactive channel ignores edges
    wr(3'd0, 8'h0c);
    step(0, 1'b1); step(1, 1'b1);
    check_all("R5 inactive");
    step(0, 1'b0); step(1, 1'b0);

    // R3 exact latency on rising edge
    wr(3'd0, 8'h05);
    @(negedge clk); v = tmr; pin[0] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R3 irq not yet", {31'd0, irq[0]}, 32'd0);
    @(posedge clk); #1;
    chk("R3 irq after k+2", {31'd0, irq[0]}, 32'd1);
    flag_m[0] = 1'b1; cap_m[0] = v + 16'd2;
    check_all("R3 latency");

    // R4 opposite polarity ignored
    step(0, 1'b0);
    check_all("R4 falling ignored");

    // R6 rewriting control with steady pins
    wr(3'd0, 8'h03);
    wr(3'd0, 8'h0f);
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h07);
    repeat (4) @(posedge clk);
    check_all("R6 ctrl change");

    // R7 write 0 has no effect, write 1 clears
    wr(3'd1, 8'h00);
    check_all("R7 write zero");
    wr(3'd1, 8'h01);
    check_all("R7 clear");

    // R8 overrun, R10 other channel untouched
    wr(3'd0, 8'h05);
    step(0, 1'b1); step(0, 1'b0); step(0, 1'b1);
    chk("R8 overrun", {30'd0, ovr_m}, 32'h1);
    check_all("R8 R10 overrun");
    wr(3'd1, 8'h01);
    check_all("R8 overrun stays");
    wr(3'd1, 8'h04);
    check_all("R8 overrun clear");

    // R9 snapshot across a later capture
    first = cap_m[0];
    step(0, 1'b0);
    rd(3'd2, lo);
    chk("R9 low byte", {24'd0, lo}, {24'd0, first[7:0]});
    repeat (300) @(posedge clk);
    step(0, 1'b1);
    rd(3'd3, hi);
    chk("R9 high snapshot", {24'd0, hi}, {24'd0, first[15:8]});
    check_all("R9 fresh read");

    // random mix
    for (int i = 0; i < 200; i++) begin
      int unsigned r;
      r = $urandom % 8;
      if (r < 2) begin
        logic [7:0] cv;
        cv = 8'($urandom % 16);
        wr(3'd0, cv);
        chk("R2 random claim", {30'd0, claim}, {30'd0, cv[1:0]});
      end else if (r < 7) begin
        int c;
        c = int'($urandom % 2);
        step(c, ~pin[c]);
      end else begin
        wr(3'd1, 8'($urandom % 16));
      end
      if (i % 4 == 3) check_all("R10 random");
    end
    check_all("R7 final");
    finish_run();
  end
endmodule